// File: doc/BRIEF.md
# Sequential-Access Configuration NVRAM Port

This block holds a 160-byte battery-backed configuration image that software can reach only as a stream. It exposes four byte ports on a small access bus: a mode/status port, a data-read port, a data-write port and a scratch port. An internal signed pointer selects the current byte. Every data-read or data-write access advances the pointer by one. Writing the start code 0x80 to the mode port sets the pointer to -1, so the first data access after that code falls outside the store and has no effect on it. The host then streams the image in order.

The status byte reports the mode register's upper bits and a ready indication. It also carries the floppy disk change line, which arrives as one input bit, and it has fixed one bits. A sticky dirty flag tells the save logic outside the block that the image has changed. A single clear pulse re-arms it. The store, the pointer, the mode register and the dirty flag all start from reset with the store filled with 0x1A, which is the value an unsaved image holds.

Top module: `cfg_stream_nvram`

## Requirements
- R1: After reset the pointer is 0, the mode register is 0x00, `dirty` is 0 and every stored byte reads as 0x1A.
- R2: A write to the mode port (`acc_sel`=0) stores the byte as the mode register. If the byte is 0x80, the pointer also becomes -1, so the next data access misses the store (a read returns 0xFF and a write is discarded) and only the access after it reaches byte 0.
- R3: A read of the data-read port (`acc_sel`=1) returns the byte at the pointer when 0 ≤ pointer ≤ 159, otherwise 0xFF. The pointer then increments.
- R4: A write to the data-write port (`acc_sel`=2) stores the byte only when 0 ≤ pointer ≤ 159. The pointer increments in every case, and an out-of-range write changes neither the store nor `dirty`.
- R5: A stored byte that differs from the previous content sets `dirty` one cycle later. A write of an identical value does not set it. Once set, `dirty` stays at 1 until it is cleared.
- R6: A `dirty_clr` pulse clears `dirty` on the next cycle. If a differing store happens in the same cycle, the set wins.
- R7: A read of the mode/status port returns bits 7:6 = mode[7:6], bit 5 = 1, bit 4 = `disk_chg`, bits 3:1 = 1 and bit 0 = mode[6].
- R8: A write to the scratch port (`acc_sel`=3) is latched onto `scratch_q` and has no other effect. A write to the data-read port is ignored, and the pointer does not move.
- R9: Reads of the scratch port and of the data-write port return 0xFF and do not move the pointer.
- R10: The pointer is a signed 9-bit register. It saturates at +255 instead of wrapping, so any run of data accesses starting at or above 160 never reaches the store again until the next start code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| acc_en | input | 1 | Access strobe, one access per cycle |
| acc_wr | input | 1 | 1 = write access, 0 = read access |
| acc_sel | input | 2 | Port code: 0 mode/status, 1 data-read, 2 data-write, 3 scratch |
| acc_wdata | input | 8 | Write data |
| acc_rdata | output | 8 | Read data for the selected port, combinational |
| disk_chg | input | 1 | Floppy change-line level reported in the status byte |
| dirty_clr | input | 1 | Clears the dirty flag |
| dirty | output | 1 | Sticky flag: the store has changed |
| scratch_q | output | 8 | Last value written to the scratch port |

## Verification
The pointer cannot be read directly. A wrong pointer therefore shows up on the next data-read as a byte from the wrong address, or as 0xFF where data was expected. The reverse also happens: data appears where 0xFF was expected. That second case is how wrapping in place of saturation becomes visible, after more than 512 reads. A store fault shows when the byte is read back in a later pass. A dirty-flag fault shows on `dirty` one cycle after the write or the clear. Random streams interleave start codes with reads and writes on every port, so every off-by-one in the pointer is caught at the next read of that address.

// File: rtl/cfgnv_pkg.sv
package cfgnv_pkg;
  localparam int BYTE_W = 8;

  typedef enum logic [1:0] {
    PORT_MODE  = 2'd0,
    PORT_RDATA = 2'd1,
    PORT_WDATA = 2'd2,
    PORT_SCR   = 2'd3
  } port_e;

  localparam logic [BYTE_W-1:0] START_CODE = 8'h80;
  localparam logic [BYTE_W-1:0] MISS_BYTE  = 8'hFF;
endpackage

// File: rtl/cfgnv_rst_sync.sv
module cfgnv_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic meta_q;
  logic sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 1'b0;
      sync_q <= 1'b0;
    end else begin
      meta_q <= 1'b1;
      sync_q <= meta_q;
    end
  end

  assign rst_sync_n = sync_q;
endmodule

// File: rtl/cfgnv_ptr.sv
module cfgnv_ptr #(
  parameter int PTR_W = 9,
  parameter int DEPTH = 160
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     step_i,
  input  logic                     load_i,
  output logic                     in_range_o,
  output logic [$clog2(DEPTH)-1:0] idx_o
);
  localparam int IDX_W = $clog2(DEPTH);
  localparam logic [PTR_W-1:0] PTR_MAX   = {1'b0, {(PTR_W-1){1'b1}}};
  localparam logic [PTR_W-1:0] PTR_START = {PTR_W{1'b1}};
  localparam logic [PTR_W-1:0] DEPTH_V   = PTR_W'(DEPTH);

  logic [PTR_W-1:0] ptr_q;
  logic [PTR_W-1:0] ptr_d;
  logic             ptr_en;

  always_comb begin
    ptr_en = 1'b0;
    ptr_d  = ptr_q;
    if (load_i) begin
      ptr_en = 1'b1;
      ptr_d  = PTR_START;
    end else if (step_i && (ptr_q != PTR_MAX)) begin
      ptr_en = 1'b1;
      ptr_d  = ptr_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q <= '0;
    end else if (ptr_en) begin
      ptr_q <= ptr_d;
    end
  end

  assign in_range_o = !ptr_q[PTR_W-1] && (ptr_q < DEPTH_V);
  assign idx_o      = ptr_q[IDX_W-1:0];

  // R2
  start_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> (ptr_q == PTR_START));

  // R3
  ptr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step_i && !load_i && ptr_q != PTR_MAX) |=> (ptr_q == $past(ptr_q) + 1'b1));

  // R10
  ptr_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step_i && !load_i && ptr_q == PTR_MAX) |=> (ptr_q == PTR_MAX));
endmodule

// File: rtl/cfgnv_store.sv
module cfgnv_store #(
  parameter int DEPTH = 160,
  parameter int DW    = 8,
  parameter logic [DW-1:0] FILL = 8'h1A
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     we_i,
  input  logic                     in_range_i,
  input  logic [$clog2(DEPTH)-1:0] idx_i,
  input  logic [DW-1:0]            wdata_i,
  input  logic                     clr_i,
  output logic [DW-1:0]            rbyte_o,
  output logic                     dirty_o
);
  localparam int IDX_W = $clog2(DEPTH);

  logic [DW-1:0] mem_q [DEPTH];
  logic [DW-1:0] cur_byte;
  logic          hit;
  logic          differs;
  logic          dirty_q;
  logic          dirty_d;

  assign hit      = we_i && in_range_i;
  assign cur_byte = in_range_i ? mem_q[idx_i] : FILL;
  assign differs  = hit && (cur_byte != wdata_i);

  for (genvar g = 0; g < DEPTH; g++) begin : g_cell
    logic cell_en;
    assign cell_en = hit && (idx_i == IDX_W'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        mem_q[g] <= FILL;
      end else if (cell_en) begin
        mem_q[g] <= wdata_i;
      end
    end
  end

  always_comb begin
    dirty_d = dirty_q;
    if (differs) begin
      dirty_d = 1'b1;
    end else if (clr_i) begin
      dirty_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dirty_q <= 1'b0;
    end else begin
      dirty_q <= dirty_d;
    end
  end

  assign rbyte_o = cur_byte;
  assign dirty_o = dirty_q;

  // R5
  dirty_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dirty_q && !clr_i) |=> dirty_q);

  // R6
  dirty_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && !we_i) |=> !dirty_q);

  // R4
  miss_no_dirty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (we_i && !in_range_i && !dirty_q && !clr_i) |=> !dirty_q);
endmodule

// File: rtl/cfgnv_rdmux.sv
module cfgnv_rdmux
  import cfgnv_pkg::*;
(
  input  port_e             sel_i,
  input  logic [BYTE_W-1:0] mode_i,
  input  logic              disk_chg_i,
  input  logic              in_range_i,
  input  logic [BYTE_W-1:0] rbyte_i,
  output logic [BYTE_W-1:0] rdata_o
);
  always_comb begin
    unique case (sel_i)
      PORT_MODE:  rdata_o = {mode_i[7:6], 1'b1, disk_chg_i, 3'b111, mode_i[6]};
      PORT_RDATA: rdata_o = in_range_i ? rbyte_i : MISS_BYTE;
      default:    rdata_o = MISS_BYTE;
    endcase
  end
endmodule

// File: rtl/cfg_stream_nvram.sv
module cfg_stream_nvram
  import cfgnv_pkg::*;
#(
  parameter int DEPTH = 160,
  parameter int PTR_W = 9,
  parameter logic [7:0] FILL = 8'h1A
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       acc_en,
  input  logic       acc_wr,
  input  logic [1:0] acc_sel,
  input  logic [7:0] acc_wdata,
  output logic [7:0] acc_rdata,
  input  logic       disk_chg,
  input  logic       dirty_clr,
  output logic       dirty,
  output logic [7:0] scratch_q
);
  localparam int IDX_W = $clog2(DEPTH);

  logic              rst_i_n;
  port_e             sel;
  logic              mode_we, scr_we, data_we, step, load;
  logic [BYTE_W-1:0] mode_q, mode_d, scr_q, scr_d;
  logic              in_range;
  logic [IDX_W-1:0]  idx;
  logic [BYTE_W-1:0] rbyte;

  cfgnv_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_sync_n(rst_i_n));

  assign sel     = port_e'(acc_sel);
  assign mode_we = acc_en && acc_wr && (sel == PORT_MODE);
  assign scr_we  = acc_en && acc_wr && (sel == PORT_SCR);
  assign data_we = acc_en && acc_wr && (sel == PORT_WDATA);
  assign load    = mode_we && (acc_wdata == START_CODE);
  assign step    = data_we || (acc_en && !acc_wr && (sel == PORT_RDATA));

  always_comb begin
    mode_d = mode_we ? acc_wdata : mode_q;
    scr_d  = scr_we  ? acc_wdata : scr_q;
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      mode_q <= '0;
      scr_q  <= '0;
    end else begin
      mode_q <= mode_d;
      scr_q  <= scr_d;
    end
  end

  cfgnv_ptr #(.PTR_W(PTR_W), .DEPTH(DEPTH)) u_ptr (
    .clk(clk), .rst_n(rst_i_n), .step_i(step), .load_i(load),
    .in_range_o(in_range), .idx_o(idx)
  );

  cfgnv_store #(.DEPTH(DEPTH), .DW(BYTE_W), .FILL(FILL)) u_store (
    .clk(clk), .rst_n(rst_i_n), .we_i(data_we), .in_range_i(in_range),
    .idx_i(idx), .wdata_i(acc_wdata), .clr_i(dirty_clr),
    .rbyte_o(rbyte), .dirty_o(dirty)
  );

  cfgnv_rdmux u_rdmux (
    .sel_i(sel), .mode_i(mode_q), .disk_chg_i(disk_chg),
    .in_range_i(in_range), .rbyte_i(rbyte), .rdata_o(acc_rdata)
  );

  assign scratch_q = scr_q;

  // R8
  scratch_isolated_chk: assert property (@(posedge clk) disable iff (!rst_i_n)
    scr_we |=> ($stable(mode_q) && $stable(dirty) || $past(dirty_clr)));

  // R2
  mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_i_n)
    !mode_we |=> $stable(mode_q));
endmodule

// File: tb/cfg_stream_nvram_tb_top.sv
module cfg_stream_nvram_tb_top;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       acc_en, acc_wr, disk_chg, dirty_clr;
  logic [1:0] acc_sel;
  logic [7:0] acc_wdata;
  logic [7:0] acc_rdata;
  logic       dirty;
  logic [7:0] scratch_q;

  int n_checks = 0;
  int n_fail   = 0;

  logic [7:0] m_mem [160];
  int         m_ptr;
  logic [7:0] m_mode, m_scr;
  logic       m_dirty;

  always #10 clk = ~clk;

  cfg_stream_nvram dut_i (
    .clk(clk), .rst_n(rst_n), .acc_en(acc_en), .acc_wr(acc_wr),
    .acc_sel(acc_sel), .acc_wdata(acc_wdata), .acc_rdata(acc_rdata),
    .disk_chg(disk_chg), .dirty_clr(dirty_clr), .dirty(dirty),
    .scratch_q(scratch_q)
  );

  function automatic logic [7:0] exp_rd(input logic [1:0] s);
    if (s == 2'd0) return {m_mode[7:6], 1'b1, disk_chg, 3'b111, m_mode[6]};
    if (s == 2'd1) return (m_ptr >= 0 && m_ptr < 160) ? m_mem[m_ptr] : 8'hFF;
    return 8'hFF;
  endfunction

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic step_model(input logic [1:0] s, input logic w, input logic [7:0] d, input logic clr);
    logic diff = 1'b0;
    if (s == 2'd0 && w) begin
      m_mode = d;
      if (d == 8'h80) m_ptr = -1;
    end else if (s == 2'd1 && !w) begin
      if (m_ptr < 255) m_ptr++;
    end else if (s == 2'd2 && w) begin
      if (m_ptr >= 0 && m_ptr < 160) begin
        diff = (m_mem[m_ptr] != d);
        m_mem[m_ptr] = d;
      end
      if (m_ptr < 255) m_ptr++;
    end else if (s == 2'd3 && w) begin
      m_scr = d;
    end
    if (diff) m_dirty = 1'b1;
    else if (clr) m_dirty = 1'b0;
  endtask

  task automatic op(input logic [1:0] s, input logic w, input logic [7:0] d,
                    input logic clr, input string req);
    @(negedge clk);
    acc_en = 1'b1; acc_wr = w; acc_sel = s; acc_wdata = d; dirty_clr = clr;
    #2;
    if (!w) check(req, acc_rdata, exp_rd(s));
    @(posedge clk);
    step_model(s, w, d, clr);
    #2;
    acc_en = 1'b0; dirty_clr = 1'b0;
    check("R5/R6 dirty", {7'd0, dirty}, {7'd0, m_dirty});
    check("R8 scratch", scratch_q, m_scr);
  endtask

  initial begin
    #(20 * 200000);
    n_fail++;
    $display("FAIL watchdog actual=running expected=done");
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd7274));
    rst_n = 1'b0; acc_en = 1'b0; acc_wr = 1'b0; acc_sel = 2'd0;
    acc_wdata = 8'h00; disk_chg = 1'b0; dirty_clr = 1'b0;
    for (int i = 0; i < 160; i++) m_mem[i] = 8'h1A;
    m_ptr = 0; m_mode = 8'h00; m_scr = 8'h00; m_dirty = 1'b0;
    repeat (3) @(posedge clk);
    #3 rst_n = 1'b1;
    repeat (4) @(posedge clk);

    // R1 reset state
    #3 check("R1 dirty", {7'd0, dirty}, 8'h00);
    op(2'd0, 1'b0, 8'h00, 1'b0, "R1 status");
    op(2'd1, 1'b0, 8'h00, 1'b0, "R1 byte0");
    op(2'd1, 1'b0, 8'h00, 1'b0, "R1 byte1");
    // R2 start code swallows the first access
    op(2'd0, 1'b1, 8'h80, 1'b0, "R2");
    op(2'd0, 1'b0, 8'h00, 1'b0, "R7 status mode 80");
    op(2'd1, 1'b0, 8'h00, 1'b0, "R2 first read misses");
    op(2'd1, 1'b0, 8'h00, 1'b0, "R3 byte0");
    // R5 identical write keeps dirty low, differing write sets it
    op(2'd0, 1'b1, 8'h80, 1'b0, "R2");
    op(2'd2, 1'b1, 8'h55, 1'b0, "R2 swallowed write");
    op(2'd2, 1'b1, 8'h1A, 1'b0, "R5 same value");
    op(2'd2, 1'b1, 8'h33, 1'b0, "R5 differ");
    op(2'd2, 1'b1, 8'h44, 1'b1, "R6 set wins");
    op(2'd3, 1'b0, 8'h00, 1'b1, "R6 clear");
    // R8 ignored write to data-read port, R9 reads returning FF
    op(2'd1, 1'b1, 8'hAA, 1'b0, "R8");
    op(2'd3, 1'b1, 8'h5C, 1'b0, "R8");
    op(2'd2, 1'b0, 8'h00, 1'b0, "R9 wdata read");
    op(2'd3, 1'b0, 8'h00, 1'b0, "R9 scratch read");
    op(2'd0, 1'b1, 8'h80, 1'b0, "R2");
    for (int i = 0; i < 4; i++) op(2'd1, 1'b0, 8'h00, 1'b0, "R4 readback");
    // R7 status with mode 40 and change line high
    disk_chg = 1'b1;
    op(2'd0, 1'b1, 8'h40, 1'b0, "R7");
    op(2'd0, 1'b0, 8'h00, 1'b0, "R7 status");
    disk_chg = 1'b0;
    // R10 long read run: would wrap back into the store after 512 steps
    for (int i = 0; i < 620; i++) op(2'd1, 1'b0, 8'h00, 1'b0, "R10 saturated");
    // R4 writes beyond the end
    op(2'd2, 1'b1, 8'h99, 1'b0, "R4");

    for (int i = 0; i < 4000; i++) begin
      int  r = int'($urandom_range(0, 99));
      logic [1:0] s;
      logic w;
      logic [7:0] d = 8'($urandom());
      string tag;
      disk_chg = 1'($urandom());
      if (r < 4) begin s = 2'd0; w = 1'b1; d = 8'h80; end
      else if (r < 40) begin s = 2'd1; w = 1'b0; end
      else if (r < 75) begin s = 2'd2; w = 1'b1; if (r < 50) d = d & 8'h03; end
      else begin s = 2'($urandom()); w = 1'($urandom()); if (s == 2'd0 && w && d == 8'h80) d = 8'h81; end
      tag = (s == 2'd0) ? "R7" : (s == 2'd1) ? "R3" : "R9";
      op(s, w, d, ($urandom_range(0, 9) == 0), tag);
    end
    op(2'd0, 1'b1, 8'h80, 1'b0, "R2");
    for (int i = 0; i < 161; i++) op(2'd1, 1'b0, 8'h00, 1'b0, "R4 final readback");

    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule